// File: doc/BRIEF.md
# Register-Indirect Port Write Sequencer

This block runs the "write a register to an I/O port" instruction of an 8-bit processor core. When the decoder has the second byte of the prefixed opcode, it pulses `start_i` with that byte on `op_byte_i` and the register file values on the `r*_i` inputs. The block then steps through three machine cycles of four clock states each.

The first two machine cycles stand in for the fetches of the prefix byte and the opcode byte. They only drive timing and status. The third is an I/O write cycle. In that cycle the B:C register pair forms the 16-bit port address, with C on the low byte and B on the high byte. The register named by the opcode's three-bit source field goes on the data bus. The port-request and write strobes frame the transfer.

A wait input can stretch the write cycle one state at a time. A one-state done pulse marks the last state of the instruction. The reserved field code 110 does not name a register. A build parameter makes it drive a fixed fill byte of 0x00 or 0xFF instead.

Top module: `port_write_seq`

## Requirements
- R1: While reset is held and after it is released with no start, `addr_o` and `data_o` are 0, `iorq_o`, `wr_o`, `fetch_o` and `done_o` are low, and `mcyc_o` is 0 (idle).
- R2: A `start_i` pulse seen in idle begins the instruction in the next state. `mcyc_o` reads 1 for four states, then 2 for four states, then 3 for the write cycle. `fetch_o` is high during codes 1 and 2 only. Without waits the instruction occupies exactly 12 states.
- R3: During every state of the write cycle, `addr_o` equals {B, C}: register B on bits 15..8 and register C on bits 7..0. Outside the write cycle `addr_o` is 0.
- R4: The source field is `op_byte_i` bits 5..3, with B=000, C=001, D=010, E=011, H=100, L=101 and A=111. Throughout the write cycle `data_o` carries the selected register, and outside it `data_o` is 0.
- R5: Field code 110 drives 0x00 on `data_o` when parameter FILL_ONES is 0, and 0xFF when it is 1.
- R6: `iorq_o` and `wr_o` are high from the second state of the write cycle through its last state, wait states included. They are low in every other state.
- R7: The opcode byte and register values are captured at start. Later changes to these inputs have no effect on `addr_o` or `data_o` during that instruction.
- R8: `wait_i` is sampled at the end of the write cycle's second state and at the end of each wait state. Each high sample inserts one more wait state before the final two states.
- R9: `wait_i` has no effect in any other state, including both fetch cycles and the final two states of the write cycle.
- R10: `done_o` is high for exactly one state, the final state of the write cycle, and the block is idle in the following state.
- R11: A `start_i` pulse while an instruction is running is ignored and does not alter its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin the instruction (acted on only when idle) |
| op_byte_i | input | 8 | Second opcode byte carrying the source field in bits 5..3 |
| rb_i | input | 8 | Register B (port address high byte, source code 000) |
| rc_i | input | 8 | Register C (port address low byte, source code 001) |
| rd_i | input | 8 | Register D (source code 010) |
| re_i | input | 8 | Register E (source code 011) |
| rh_i | input | 8 | Register H (source code 100) |
| rl_i | input | 8 | Register L (source code 101) |
| ra_i | input | 8 | Accumulator (source code 111) |
| wait_i | input | 1 | Wait request, stretches the write cycle |
| addr_o | output | 16 | Port address bus |
| data_o | output | 8 | Write data bus |
| iorq_o | output | 1 | Port request strobe |
| wr_o | output | 1 | Write strobe |
| fetch_o | output | 1 | Opcode-fetch cycle status |
| mcyc_o | output | 2 | Machine cycle: 0 idle, 1 and 2 fetch, 3 port write |
| done_o | output | 1 | Last state of the instruction |

## Verification
The assertions assume that a start seen in idle carries a well-formed second opcode byte, 01 in bits 7..6 and 001 in bits 2..0, with only the source field varying. The bench only ever builds the byte from that pattern. They also take the reset as synchronous and the inputs as settled before each rising edge. The bench guarantees this by changing every input one nanosecond after an edge. Within those limits the stimulus deliberately holds `wait_i` high in states where it must be ignored. It also repeats `start_i` and rewrites the register inputs mid-instruction, so the behaviour that should be insensitive to these is exercised rather than assumed.

// File: rtl/port_wr_pkg.sv
package port_wr_pkg;

    localparam int DW   = 8;
    localparam int AW   = 2 * DW;
    localparam int FW   = 3;
    localparam int FLSB = 3;
    localparam int TW_W = 3;

    localparam logic [FW-1:0] CODE_B   = 3'b000;
    localparam logic [FW-1:0] CODE_C   = 3'b001;
    localparam logic [FW-1:0] CODE_D   = 3'b010;
    localparam logic [FW-1:0] CODE_E   = 3'b011;
    localparam logic [FW-1:0] CODE_H   = 3'b100;
    localparam logic [FW-1:0] CODE_L   = 3'b101;
    localparam logic [FW-1:0] CODE_MEM = 3'b110;

    typedef enum logic [1:0] {
        MC_IDLE   = 2'd0,
        MC_FETCH1 = 2'd1,
        MC_FETCH2 = 2'd2,
        MC_IOWR   = 2'd3
    } mcyc_e;

    typedef enum logic [TW_W-1:0] {
        TS_T1,
        TS_T2,
        TS_TW,
        TS_T3,
        TS_T4
    } tstate_e;

    typedef struct packed {
        logic [DW-1:0] b;
        logic [DW-1:0] c;
        logic [DW-1:0] d;
        logic [DW-1:0] e;
        logic [DW-1:0] h;
        logic [DW-1:0] l;
        logic [DW-1:0] a;
    } regset_t;

    typedef struct packed {
        logic [FW-1:0] field;
        regset_t       regs;
    } capture_t;

    function automatic logic [AW-1:0] port_addr(input regset_t r);
        return {r.b, r.c};
    endfunction

    function automatic logic wait_window(input tstate_e t);
        return (t == TS_T2) || (t == TS_TW);
    endfunction

    function automatic tstate_e fixed_next(input tstate_e t);
        case (t)
            TS_T1:   return TS_T2;
            TS_T2:   return TS_T3;
            TS_TW:   return TS_T3;
            TS_T3:   return TS_T4;
            default: return TS_T1;
        endcase
    endfunction

endpackage

// File: rtl/pw_regcap.sv
module pw_regcap
    import port_wr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [DW-1:0] op_byte,
    input  regset_t       regs_i,
    output capture_t      cap_o
);

    capture_t cap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q <= '0;
        end else if (load) begin
            cap_q.field <= op_byte[FLSB +: FW];
            cap_q.regs  <= regs_i;
        end
    end

    assign cap_o = cap_q;

    AST_OPC_FORM: assert property (@(posedge clk) disable iff (rst)
        load |-> (op_byte[DW-1 -: 2] == 2'b01) && (op_byte[FLSB-1:0] == 3'b001)); // R4

    AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(cap_q)); // R7

endmodule

// File: rtl/pw_srcsel.sv
module pw_srcsel
    import port_wr_pkg::*;
#(
    parameter bit FILL_ONES = 1'b0
) (
    input  capture_t      cap,
    output logic [DW-1:0] byte_o
);

    logic [DW-1:0] fill;

    generate
        if (FILL_ONES) begin : g_fill_ones
            assign fill = {DW{1'b1}};
        end else begin : g_fill_zero
            assign fill = {DW{1'b0}};
        end
    endgenerate

    always_comb begin
        case (cap.field)
            CODE_B:   byte_o = cap.regs.b;
            CODE_C:   byte_o = cap.regs.c;
            CODE_D:   byte_o = cap.regs.d;
            CODE_E:   byte_o = cap.regs.e;
            CODE_H:   byte_o = cap.regs.h;
            CODE_L:   byte_o = cap.regs.l;
            CODE_MEM: byte_o = fill;
            default:  byte_o = cap.regs.a;
        endcase
    end

endmodule

// File: rtl/pw_tseq.sv
module pw_tseq
    import port_wr_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  logic    wait_in,
    output mcyc_e   mc_o,
    output tstate_e ts_o,
    output logic    launch_o,
    output logic    done_o
);

    mcyc_e   mc_q, mc_d;
    tstate_e ts_q, ts_d;

    assign launch_o = (mc_q == MC_IDLE) && start;
    assign done_o   = (mc_q == MC_IOWR) && (ts_q == TS_T4);

    always_comb begin
        mc_d = mc_q;
        ts_d = ts_q;
        case (mc_q)
            MC_IDLE: begin
                if (start) begin
                    mc_d = MC_FETCH1;
                    ts_d = TS_T1;
                end
            end
            MC_FETCH1, MC_FETCH2: begin
                ts_d = fixed_next(ts_q);
                if (ts_q == TS_T4) begin
                    mc_d = (mc_q == MC_FETCH1) ? MC_FETCH2 : MC_IOWR;
                end
            end
            default: begin
                if (wait_window(ts_q)) begin
                    ts_d = wait_in ? TS_TW : TS_T3;
                end else begin
                    ts_d = fixed_next(ts_q);
                end
                if (ts_q == TS_T4) begin
                    mc_d = MC_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mc_q <= MC_IDLE;
            ts_q <= TS_T1;
        end else begin
            mc_q <= mc_d;
            ts_q <= ts_d;
        end
    end

    assign mc_o = mc_q;
    assign ts_o = ts_q;

    AST_WAIT_STRETCH: assert property (@(posedge clk) disable iff (rst)
        (mc_q == MC_IOWR && wait_window(ts_q) && wait_in) |=> (ts_q == TS_TW)); // R8

    AST_WAIT_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (mc_q == MC_IOWR && wait_window(ts_q) && !wait_in) |=> (ts_q == TS_T3)); // R8

    AST_NO_FETCH_WAIT: assert property (@(posedge clk) disable iff (rst)
        (mc_q != MC_IOWR) |-> (ts_q != TS_TW)); // R9

    AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (mc_q == MC_IDLE) && !done_o); // R10

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (start && mc_q == MC_IOWR && ts_q != TS_T4) |=> (mc_q == MC_IOWR)); // R11

endmodule

// File: rtl/port_write_seq.sv
module port_write_seq
    import port_wr_pkg::*;
#(
    parameter bit FILL_ONES = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic [DW-1:0] op_byte_i,
    input  logic [DW-1:0] rb_i,
    input  logic [DW-1:0] rc_i,
    input  logic [DW-1:0] rd_i,
    input  logic [DW-1:0] re_i,
    input  logic [DW-1:0] rh_i,
    input  logic [DW-1:0] rl_i,
    input  logic [DW-1:0] ra_i,
    input  logic          wait_i,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] data_o,
    output logic          iorq_o,
    output logic          wr_o,
    output logic          fetch_o,
    output logic [1:0]    mcyc_o,
    output logic          done_o
);

    regset_t       regs_in;
    capture_t      cap;
    mcyc_e         mc;
    tstate_e       ts;
    logic          launch;
    logic [DW-1:0] src_byte;
    logic          in_io;

    always_comb begin
        regs_in.b = rb_i;
        regs_in.c = rc_i;
        regs_in.d = rd_i;
        regs_in.e = re_i;
        regs_in.h = rh_i;
        regs_in.l = rl_i;
        regs_in.a = ra_i;
    end

    pw_tseq u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start_i),
        .wait_in  (wait_i),
        .mc_o     (mc),
        .ts_o     (ts),
        .launch_o (launch),
        .done_o   (done_o)
    );

    pw_regcap u_cap (
        .clk     (clk),
        .rst     (rst),
        .load    (launch),
        .op_byte (op_byte_i),
        .regs_i  (regs_in),
        .cap_o   (cap)
    );

    pw_srcsel #(.FILL_ONES(FILL_ONES)) u_sel (
        .cap    (cap),
        .byte_o (src_byte)
    );

    assign in_io   = (mc == MC_IOWR);
    assign addr_o  = in_io ? port_addr(cap.regs) : '0;
    assign data_o  = in_io ? src_byte : '0;
    assign iorq_o  = in_io && (ts != TS_T1);
    assign wr_o    = in_io && (ts != TS_T1);
    assign fetch_o = (mc == MC_FETCH1) || (mc == MC_FETCH2);
    assign mcyc_o  = mc;

    AST_STROBE_IN_IO: assert property (@(posedge clk) disable iff (rst)
        (iorq_o || wr_o) |-> (mcyc_o == 2'd3) && !fetch_o); // R6

    AST_STROBE_UNTIL_DONE: assert property (@(posedge clk) disable iff (rst)
        (iorq_o && !done_o) |=> iorq_o && wr_o); // R6

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        (in_io && ts != TS_T1) |-> $stable(addr_o)); // R3

    AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
        (in_io && ts != TS_T1) |-> $stable(data_o)); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (mcyc_o == 2'd0) |-> (addr_o == '0) && (data_o == '0) && !done_o); // R1

endmodule

// File: tb/tb_port_write_seq.sv
module tb_port_write_seq;

    logic        clk = 1'b0;
    logic        rst;
    logic        start_i;
    logic [7:0]  op_byte_i;
    logic [7:0]  rv [0:6];
    logic        wait_i;
    logic [15:0] addr_o;
    logic [7:0]  data_o, data_ff;
    logic        iorq_o, wr_o, fetch_o, done_o;
    logic [1:0]  mcyc_o;
    logic [15:0] addr_ff;
    logic        iorq_ff, wr_ff, fetch_ff, done_ff;
    logic [1:0]  mcyc_ff;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    port_write_seq #(.FILL_ONES(1'b0)) dut (
        .clk(clk), .rst(rst), .start_i(start_i), .op_byte_i(op_byte_i),
        .rb_i(rv[0]), .rc_i(rv[1]), .rd_i(rv[2]), .re_i(rv[3]),
        .rh_i(rv[4]), .rl_i(rv[5]), .ra_i(rv[6]), .wait_i(wait_i),
        .addr_o(addr_o), .data_o(data_o), .iorq_o(iorq_o), .wr_o(wr_o),
        .fetch_o(fetch_o), .mcyc_o(mcyc_o), .done_o(done_o)
    );

    port_write_seq #(.FILL_ONES(1'b1)) dut_ff (
        .clk(clk), .rst(rst), .start_i(start_i), .op_byte_i(op_byte_i),
        .rb_i(rv[0]), .rc_i(rv[1]), .rd_i(rv[2]), .re_i(rv[3]),
        .rh_i(rv[4]), .rl_i(rv[5]), .ra_i(rv[6]), .wait_i(wait_i),
        .addr_o(addr_ff), .data_o(data_ff), .iorq_o(iorq_ff), .wr_o(wr_ff),
        .fetch_o(fetch_ff), .mcyc_o(mcyc_ff), .done_o(done_ff)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check_idle(input string tag);
        check({tag, " mcyc"}, {14'd0, mcyc_o}, 16'd0);
        check({tag, " addr"}, addr_o, 16'd0);
        check({tag, " data"}, {8'd0, data_o}, 16'd0);
        check({tag, " strobes"}, {12'd0, iorq_o, wr_o, fetch_o, done_o}, 16'd0);
    endtask

    task automatic run(input int code, input int nw, input bit noise, input bit poke);
        logic [7:0] sv [0:6];
        logic [7:0] exp0, exp1;
        int nt;
        int mc;
        int j;
        bit st;
        nt = 12 + nw;
        for (int i = 0; i < 7; i++) begin
            rv[i] = 8'((code * 29) + (nw * 7) + (i * 53) + (poke ? 91 : 1));
            sv[i] = rv[i];
        end
        exp0 = (code == 7) ? sv[6] : (code == 6) ? 8'h00 : sv[code];
        exp1 = (code == 6) ? 8'hFF : exp0;
        op_byte_i = {2'b01, 3'(code), 3'b001};
        start_i = 1'b1;
        wait_i = noise;
        tick();
        start_i = 1'b0;
        for (int c = 1; c <= nt; c++) begin
            mc = (c <= 4) ? 1 : (c <= 8) ? 2 : 3;
            j = c - 8;
            st = (mc == 3) && (j >= 2);
            check("R2 mcyc", {14'd0, mcyc_o}, 16'(mc));
            check("R2 fetch", {15'd0, fetch_o}, {15'd0, (mc != 3)});
            check("R3 addr", addr_o, (mc == 3) ? {sv[0], sv[1]} : 16'd0);
            check(poke ? "R7 data" : "R4 data", {8'd0, data_o}, (mc == 3) ? {8'd0, exp0} : 16'd0);
            check("R5 data fill-ones build", {8'd0, data_ff}, (mc == 3) ? {8'd0, exp1} : 16'd0);
            check(nw > 0 ? "R8 strobes" : "R6 strobes", {14'd0, iorq_o, wr_o}, st ? 16'd3 : 16'd0);
            check(noise ? "R9 done" : "R10 done", {15'd0, done_o}, {15'd0, (c == nt)});
            if (poke && c == 3) begin
                start_i = 1'b1;
                op_byte_i = {2'b01, 3'(7 - code), 3'b001};
                for (int i = 0; i < 7; i++) rv[i] = ~sv[i];
            end else begin
                start_i = poke && (c == 10);
            end
            wait_i = ((c >= 10) && (c <= 9 + nw)) || (noise && ((c <= 9) || (c >= 11 + nw)));
            tick();
        end
        start_i = 1'b0;
        wait_i = 1'b0;
        check_idle(poke ? "R11 after" : "R10 after");
    endtask

    initial begin
        rst = 1'b1;
        start_i = 1'b0;
        wait_i = 1'b0;
        op_byte_i = 8'h41;
        for (int i = 0; i < 7; i++) rv[i] = 8'(i * 17 + 3);
        tick();
        check_idle("R1 in reset");
        tick();
        rst = 1'b0;
        tick();
        tick();
        check_idle("R1 after reset");
        for (int code = 0; code < 8; code++) begin
            run(code, 0, 1'b0, 1'b0);
            run(code, 1, 1'b1, 1'b0);
            run(code, 3, (code % 2) == 1, 1'b1);
            tick();
            check_idle("R10 gap");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule